// File: doc/BRIEF.md
# Synchronous Slave Packet FIFO Bank

A bank of byte-wide FIFOs that an external master fills and empties over a synchronous slave interface clocked by a single clock. A select input chooses one FIFO. Chip-select, write, read and output-enable strobes carry single-byte and burst transfers. A packet-end strobe turns everything written so far into a packet that a consumer may take. Each strobe's active level is set by a polarity input, so the block can face masters that drive active-low or active-high controls.

Bytes that the master has written stay hidden until a packet-end commits them. Once committed, they can be taken from the FIFO head in either of two ways. The master can read them through the read strobe. A drain port can also pop them, and that port sees each packet's length through a small descriptor queue. The empty and full flags always describe the FIFO that the master currently selects. The flags and pointers change only on the clock edge that changes occupancy.

Top module: `slvfifo`

## Requirements
- R1: A byte on `din` is stored, and the selected FIFO's write pointer advances, on each rising edge where both chip-select and write are active. Holding both active writes one byte per edge (burst). With chip-select inactive, nothing is stored.
- R2: While output-enable is active, `dout_en` is 1 and `dout` shows the byte at the selected FIFO's read pointer. Otherwise `dout_en` is 0. Each edge with chip-select and read active advances the pointer, so the next byte appears after that edge.
- R3: A write to a FIFO that holds DEPTH (512) bytes is ignored. A read from a FIFO with no committed bytes is ignored. In neither case does a pointer move.
- R4: An edge with chip-select and packet-end active commits every uncommitted byte of the selected FIFO, including a byte written on that same edge. It pushes the byte count onto that FIFO's descriptor queue. Packet-end may come with the last byte or on any later edge.
- R5: A packet-end with no uncommitted bytes pushes a descriptor of length 0.
- R6: Uncommitted bytes are invisible to consumers. `empty` and `dr_avail` count committed, unread bytes only.
- R7: `strobe_pol` sets the active level of each strobe: bit0 chip-select, bit1 write, bit2 read, bit3 output-enable, bit4 packet-end. A strobe is active when its pin equals its bit. 0 means active-low.
- R8: `empty` and `full` refer to the FIFO chosen by `fifo_sel`.
- R9: `dr_data` shows the head byte of FIFO `dr_sel`, and `dr_pop` pops it when `dr_avail` is nonzero. If a master read hits the same FIFO on the same edge, only the master read advances the pointer.
- R10: Each FIFO keeps up to LQD (16) descriptors. A packet-end that finds the queue full is ignored. `dr_pkt_valid` and `dr_pkt_len` show the head descriptor of `dr_sel`, and `dr_pkt_ack` pops it.
- R11: After reset, every FIFO is empty, not full, and has no descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| strobe_pol | input | 5 | Active level per strobe |
| fifo_sel | input | 2 | FIFO chosen by the master |
| cs_s | input | 1 | Chip-select strobe |
| wr_s | input | 1 | Write strobe |
| rd_s | input | 1 | Read strobe |
| oe_s | input | 1 | Output-enable strobe |
| pe_s | input | 1 | Packet-end strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (0 when output-enable is inactive) |
| dout_en | output | 1 | Output-enable is active |
| empty | output | 1 | Selected FIFO has no committed bytes |
| full | output | 1 | Selected FIFO holds DEPTH bytes |
| dr_sel | input | 2 | FIFO chosen by the drain port |
| dr_pop | input | 1 | Pop one committed byte |
| dr_data | output | 8 | Head byte of the drain FIFO |
| dr_avail | output | 10 | Committed unread bytes of the drain FIFO |
| dr_pkt_ack | input | 1 | Pop the head descriptor |
| dr_pkt_valid | output | 1 | A descriptor is pending |
| dr_pkt_len | output | 10 | Length of the head descriptor |

## Verification
Two pairs of functions can land on one edge. The first is a byte write together with packet-end: the bench asserts packet-end on the last byte of a burst and expects the descriptor length to count that byte. The second is a master read and a drain pop aimed at the same FIFO: the bench raises both before one edge and then expects the pointer to have moved by exactly one, seen through `dr_avail` and the next byte shown on `dout`. A scoreboard model of committed bytes, pending bytes and lengths supplies all expected values.

// File: rtl/slvfifo.sv
module slvfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 512,
  parameter int NF    = 4,
  parameter int LQD   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [4:0]                   strobe_pol,
  input  logic [$clog2(NF)-1:0]        fifo_sel,
  input  logic                         cs_s,
  input  logic                         wr_s,
  input  logic                         rd_s,
  input  logic                         oe_s,
  input  logic                         pe_s,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic                         dout_en,
  output logic                         empty,
  output logic                         full,
  input  logic [$clog2(NF)-1:0]        dr_sel,
  input  logic                         dr_pop,
  output logic [W-1:0]                 dr_data,
  output logic [$clog2(DEPTH):0]       dr_avail,
  input  logic                         dr_pkt_ack,
  output logic                         dr_pkt_valid,
  output logic [$clog2(DEPTH):0]       dr_pkt_len
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int SW  = $clog2(NF);
  localparam int LW  = $clog2(LQD);
  localparam int LPW = LW + 1;
  localparam logic [PW-1:0]  DEP  = PW'(DEPTH);
  localparam logic [LPW-1:0] LDEP = LPW'(LQD);

  logic [NF-1:0][PW-1:0]  wptr, rptr, cptr;
  logic [NF-1:0][LPW-1:0] lqw, lqr;
  logic [W-1:0]  mem [NF*DEPTH];
  logic [PW-1:0] lq  [NF*LQD];

  wire cs_a = cs_s == strobe_pol[0];
  wire wr_a = wr_s == strobe_pol[1];
  wire rd_a = rd_s == strobe_pol[2];
  wire oe_a = oe_s == strobe_pol[3];
  wire pe_a = pe_s == strobe_pol[4];

  wire [PW-1:0]  occ_sel = wptr[fifo_sel] - rptr[fifo_sel];
  wire [PW-1:0]  rdy_sel = cptr[fifo_sel] - rptr[fifo_sel];
  wire [LPW-1:0] lqn_sel = lqw[fifo_sel] - lqr[fifo_sel];

  assign full  = occ_sel == DEP;
  assign empty = rdy_sel == '0;

  wire wr_go = cs_a & wr_a & ~full;
  wire rd_go = cs_a & rd_a & ~empty;
  wire pe_go = cs_a & pe_a & (lqn_sel != LDEP);
  wire [PW-1:0] new_len = wptr[fifo_sel] + PW'(wr_go) - cptr[fifo_sel];

  assign dr_avail     = cptr[dr_sel] - rptr[dr_sel];
  assign dr_pkt_valid = lqw[dr_sel] != lqr[dr_sel];
  assign dr_pkt_len   = lq[{dr_sel, lqr[dr_sel][LW-1:0]}];
  assign dr_data      = mem[{dr_sel, rptr[dr_sel][AW-1:0]}];
  wire dr_go = dr_pop & (dr_avail != '0) & ~(rd_go & (fifo_sel == dr_sel));
  wire pk_go = dr_pkt_ack & dr_pkt_valid;

  assign dout_en = oe_a;
  assign dout    = oe_a ? mem[{fifo_sel, rptr[fifo_sel][AW-1:0]}] : '0;

  always_ff @(posedge clk) begin
    if (wr_go) mem[{fifo_sel, wptr[fifo_sel][AW-1:0]}] <= din;
    if (pe_go) lq[{fifo_sel, lqw[fifo_sel][LW-1:0]}] <= new_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cptr <= '0;
      lqw  <= '0;
      lqr  <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (wr_go && fifo_sel == SW'(i)) wptr[i] <= wptr[i] + 1'b1;
        if (pe_go && fifo_sel == SW'(i)) begin
          cptr[i] <= wptr[i] + PW'(wr_go);
          lqw[i]  <= lqw[i] + 1'b1;
        end
        if (rd_go && fifo_sel == SW'(i))     rptr[i] <= rptr[i] + 1'b1;
        else if (dr_go && dr_sel == SW'(i))  rptr[i] <= rptr[i] + 1'b1;
        if (pk_go && dr_sel == SW'(i))       lqr[i] <= lqr[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slvfifo_chk.sv
module slvfifo_chk #(
  parameter int NF    = 4,
  parameter int PW    = 10,
  parameter int SW    = 2,
  parameter int DEPTH = 512
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            pol,
  input logic [SW-1:0]         sel,
  input logic                  cs_s,
  input logic                  wr_s,
  input logic                  rd_s,
  input logic                  empty,
  input logic                  full,
  input logic [NF-1:0][PW-1:0] wptr,
  input logic [NF-1:0][PW-1:0] rptr,
  input logic [NF-1:0][PW-1:0] cptr
);
  wire cs_a = cs_s == pol[0];
  wire wr_a = wr_s == pol[1];
  wire rd_a = rd_s == pol[2];

  for (genvar i = 0; i < NF; i++) begin : g_inv
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      PW'(wptr[i] - rptr[i]) <= PW'(DEPTH));
    a_r6_commit_window: assert property (@(posedge clk) disable iff (!rst_n)
      PW'(cptr[i] - rptr[i]) <= PW'(wptr[i] - rptr[i]));
  end

  a_r1_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
    cs_a && wr_a && !full |=> wptr[$past(sel)] == $past(wptr[sel]) + 1'b1);
  a_r1_no_cs_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_a |=> $stable(wptr));
  a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cs_a && wr_a && full |=> wptr[$past(sel)] == $past(wptr[sel]));
  a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cs_a && rd_a && empty |=> rptr[$past(sel)] == $past(rptr[sel]));
endmodule

bind slvfifo slvfifo_chk #(.NF(NF), .PW(PW), .SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol(strobe_pol[2:0]), .sel(fifo_sel),
  .cs_s(cs_s), .wr_s(wr_s), .rd_s(rd_s), .empty(empty), .full(full),
  .wptr(wptr), .rptr(rptr), .cptr(cptr));

// File: tb/slvfifo_test.sv
module slvfifo_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] pol = 5'b00000;
  logic [1:0] fifo_sel = 0, dr_sel = 0;
  logic cs_s, wr_s, rd_s, oe_s, pe_s;
  logic [7:0] din = 0;
  logic dr_pop = 0, dr_pkt_ack = 0;
  logic [7:0] dout, dr_data;
  logic dout_en, empty, full, dr_pkt_valid;
  logic [9:0] dr_avail, dr_pkt_len;

  slvfifo uut (.clk(clk), .rst_n(rst_n), .strobe_pol(pol), .fifo_sel(fifo_sel),
    .cs_s(cs_s), .wr_s(wr_s), .rd_s(rd_s), .oe_s(oe_s), .pe_s(pe_s), .din(din),
    .dout(dout), .dout_en(dout_en), .empty(empty), .full(full), .dr_sel(dr_sel),
    .dr_pop(dr_pop), .dr_data(dr_data), .dr_avail(dr_avail), .dr_pkt_ack(dr_pkt_ack),
    .dr_pkt_valid(dr_pkt_valid), .dr_pkt_len(dr_pkt_len));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] expq [4][$];
  logic [7:0] pendq[4][$];
  int lenq [4][$];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic lv(bit a, int b);
    return a ? pol[b] : ~pol[b];
  endfunction

  task automatic drive(bit cs, bit wr, bit rd, bit oe, bit pe);
    cs_s = lv(cs, 0); wr_s = lv(wr, 1); rd_s = lv(rd, 2); oe_s = lv(oe, 3); pe_s = lv(pe, 4);
  endtask

  task automatic model_edge(int f, bit w, logic [7:0] d, bit pe);
    if (w && expq[f].size() + pendq[f].size() < 512) pendq[f].push_back(d);
    if (pe && lenq[f].size() < 16) begin
      lenq[f].push_back(pendq[f].size());
      while (pendq[f].size() > 0) expq[f].push_back(pendq[f].pop_front());
    end
  endtask

  task automatic wburst(int f, int n, int base, bit pe_last, bit cs);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fifo_sel = 2'(f); din = 8'(base + k * 7);
      drive(cs, 1, 0, 0, pe_last && k == n - 1);
      @(posedge clk);
      if (cs) model_edge(f, 1, 8'(base + k * 7), pe_last && k == n - 1);
    end
    @(negedge clk); drive(0, 0, 0, 0, 0);
  endtask

  task automatic commit(int f);
    @(negedge clk); fifo_sel = 2'(f); drive(1, 0, 0, 0, 1);
    @(posedge clk); model_edge(f, 0, 0, 1);
    @(negedge clk); drive(0, 0, 0, 0, 0);
  endtask

  task automatic mread(int f, int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); fifo_sel = 2'(f); drive(1, 0, 1, 1, 0);
      #1;
      chk(dout_en === 1'b1, req, dout_en, 1);
      if (expq[f].size() > 0) begin
        chk(dout === expq[f][0], req, dout, expq[f][0]);
        @(posedge clk); void'(expq[f].pop_front());
      end else @(posedge clk);
    end
    @(negedge clk); drive(0, 0, 0, 0, 0);
  endtask

  task automatic dpop(int f, int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); dr_sel = 2'(f); dr_pop = 1;
      #1;
      chk(dr_data === expq[f][0], req, dr_data, expq[f][0]);
      @(posedge clk); void'(expq[f].pop_front());
    end
    @(negedge clk); dr_pop = 0;
  endtask

  task automatic pkt(int f, string req);
    @(negedge clk); dr_sel = 2'(f);
    #1;
    chk(dr_pkt_valid === 1'b1, req, dr_pkt_valid, 1);
    chk(int'(dr_pkt_len) == lenq[f][0], req, dr_pkt_len, lenq[f][0]);
    dr_pkt_ack = 1;
    @(posedge clk); void'(lenq[f].pop_front());
    @(negedge clk); dr_pkt_ack = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(empty === 1'b1, "R11 empty", empty, 1);
    chk(full === 1'b0, "R11 full", full, 0);
    chk(dr_pkt_valid === 1'b0, "R11 pkt_valid", dr_pkt_valid, 0);
    chk(dout_en === 1'b0, "R2 oe idle", dout_en, 0);

    // R1: write with chip-select inactive is dropped; R5 zero-length commit
    wburst(0, 1, 8'h99, 0, 0);
    commit(0);
    #1; chk(empty === 1'b1, "R1 no-cs write", empty, 1);
    pkt(0, "R5 zero length");

    // R1 single + burst, R4 commit on the same edge as last byte, R6 hidden
    wburst(0, 1, 8'hA5, 0, 1);
    #1;
    chk(empty === 1'b1, "R6 uncommitted empty", empty, 1);
    chk(dr_avail === 10'd0, "R6 uncommitted avail", dr_avail, 0);
    wburst(0, 3, 8'h10, 1, 1);
    #1; chk(dr_avail === 10'd4, "R4 same-edge commit", dr_avail, 4);
    wburst(0, 2, 8'h40, 0, 1);
    #1; chk(dr_avail === 10'd4, "R6 pending not counted", dr_avail, 4);
    repeat (3) @(negedge clk);
    commit(0);
    #1; chk(dr_avail === 10'd6, "R4 later commit", dr_avail, 6);

    mread(0, 3, "R2 burst read");
    dpop(0, 3, "R9 drain bytes");
    pkt(0, "R4 len 4");
    pkt(0, "R4 len 2");
    #1; chk(dr_pkt_valid === 1'b0, "R10 queue drained", dr_pkt_valid, 0);

    // R9: master read and drain pop on the same FIFO and edge
    wburst(2, 2, 8'h11, 1, 1);
    @(negedge clk); fifo_sel = 2; dr_sel = 2; dr_pop = 1; drive(1, 0, 1, 1, 0);
    #1;
    chk(dout === expq[2][0], "R9 conflict dout", dout, expq[2][0]);
    chk(dr_data === expq[2][0], "R9 conflict dr_data", dr_data, expq[2][0]);
    @(posedge clk); void'(expq[2].pop_front());
    @(negedge clk); dr_pop = 0; drive(0, 0, 0, 0, 0);
    #1; chk(dr_avail === 10'd1, "R9 single advance", dr_avail, 1);
    mread(2, 1, "R9 next byte");

    // R3: read from empty FIFO ignored
    #1; chk(empty === 1'b1, "R3 empty before", empty, 1);
    @(negedge clk); fifo_sel = 2; drive(1, 0, 1, 1, 0);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    wburst(2, 1, 8'h5A, 1, 1);
    mread(2, 1, "R3 read after empty read");

    // R3/R8: fill FIFO 1, extra write ignored
    wburst(1, 513, 3, 0, 1);
    @(negedge clk); fifo_sel = 1; #1;
    chk(full === 1'b1, "R3 full", full, 1);
    fifo_sel = 3; #1;
    chk(full === 1'b0, "R8 other FIFO not full", full, 0);
    chk(empty === 1'b1, "R8 other FIFO empty", empty, 1);
    commit(1);
    pkt(1, "R3 len 512");
    dpop(1, 512, "R3 drain full");
    @(negedge clk); dr_sel = 1; #1;
    chk(dr_avail === 10'd0, "R3 extra byte not stored", dr_avail, 0);

    // R7: polarity flipped to active-high
    @(negedge clk); pol = 5'b11111; drive(0, 0, 0, 0, 0);
    @(negedge clk); fifo_sel = 3; din = 8'hEE;
    cs_s = 0; wr_s = 0; pe_s = 0; rd_s = 0; oe_s = 0;
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    #1;
    chk(dout_en === 1'b0, "R7 low oe inactive", dout_en, 0);
    chk(dr_pkt_valid === 1'b0, "R7 low pe inactive", dr_pkt_valid, 0);
    wburst(3, 3, 8'h70, 1, 1);
    pkt(3, "R7 active-high commit");
    mread(3, 3, "R7 active-high read");

    // R10: descriptor queue depth
    for (int k = 0; k < 17; k++) commit(0);
    begin
      int got = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); dr_sel = 0; #1;
        if (dr_pkt_valid) begin
          got++;
          chk(dr_pkt_len === 10'd0, "R10 zero lengths", dr_pkt_len, 0);
          dr_pkt_ack = 1;
          @(posedge clk);
          @(negedge clk); dr_pkt_ack = 0;
        end
      end
      chk(got == 16, "R10 queue limit", got, 16);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule